// File: doc/BRIEF.md
# Synchronous Parity SRAM with Address Strobe

This block is a single-clock synchronous static RAM whose words are 72 bits wide. Each word holds 64 data bits and 8 parity bits. They form eight byte lanes, and each lane is eight data bits plus one parity bit. An active-low address strobe opens each access. On a strobed edge, the chip enable decides between two outcomes. If the enable is low, the external address is latched and a read or write starts there. If the enable is high, the device is deselected. Edges without the strobe keep working on the held address, which lets a host stream repeated accesses to one word without presenting the address again.

The write strobes are active low, one per lane. If any of them is low on an edge, that edge is a write. Only the lanes whose strobe is low are updated, and the other lanes keep their contents. Read data is registered and appears one cycle after the edge that used the address. The read register keeps its value until the next read. The bidirectional bus is split into input ports, output ports and a drive enable. An asynchronous active-low output enable controls the drive enable. The address port is 16 bits wide. The stored array is sized by a separate parameter, so high address bits alias onto the stored words.

Top module: `ssr_sram`

## Requirements
- R1: While `rst` is high at a clock edge, the device becomes deselected and the held address is cleared to zero. After reset, `drive` stays low until a strobed select followed by a read.
- R2: An edge with `ads_n` low and `ce_n` high deselects the device. On the following cycle `drive` is low.
- R3: A deselect persists over every later edge with `ads_n` high. Writes on those edges leave memory unchanged, and `drive` stays low.
- R4: An edge with `ads_n` low and `ce_n` low latches `addr` and performs that edge's read or write at this address.
- R5: On an edge with `ads_n` high, `ce_n` and `addr` are ignored. If the device is selected, the access uses the held address.
- R6: An edge is a write when any bit of `we_n` is low, and a read when all eight bits are high.
- R7: Bit i of `we_n` (low = write) controls lane i, which is `dq_in[8i+7:8i]` together with `dp_in[i]`. Lanes whose strobe is high keep their stored data and parity.
- R8: `drive` equals the inverse of `oe_n` combinationally when the previous edge was a selected read, and `drive` is low otherwise.
- R9: A selected read at edge k places the addressed word on `dq_out`/`dp_out` after edge k. Those outputs hold their value over every later edge that is not a selected read.
- R10: Only the low `STORE_AW` address bits select a stored word. With the default of 10, address 0x0410 reaches the same word as 0x0010.
- R11: After any write edge, `drive` is low for the following cycle, even when `oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all synchronous inputs |
| rst | input | 1 | Synchronous active-high reset |
| ads_n | input | 1 | Active-low address strobe |
| ce_n | input | 1 | Active-low chip enable, sampled only when the strobe is low |
| addr | input | 16 | Word address |
| we_n | input | 8 | Active-low byte-lane write strobes |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | 64 | Write data, eight byte lanes |
| dp_in | input | 8 | Write parity, one bit per lane |
| dq_out | output | 64 | Registered read data |
| dp_out | output | 8 | Registered read parity |
| drive | output | 1 | High when the read bus would be driven |

## Verification
The assertions assume that `ads_n`, `ce_n`, `addr` and `we_n` have known values at every rising edge after reset. They also assume that `rst` is high on the first edge, so the held state is never read before it is set. The bench drives every synchronous input on the falling edge and holds it through the next rising edge, so no edge sees an unknown control. The bench toggles `oe_n` between edges only in the test that checks the asynchronous path of R8. The bench reads only words it has written, so uninitialised storage never reaches a compared value.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  localparam int unsigned LANE_DW = 8;
  localparam int unsigned LANE_W  = LANE_DW + 1;

  // True when any active-low strobe bit is asserted.
  function automatic logic any_low(input logic [7:0] strobes_n);
    return (strobes_n != 8'hFF);
  endfunction

  // Gather one lane: parity bit above its eight data bits.
  function automatic logic [LANE_W-1:0] lane_pick(input logic [63:0] dq,
                                                  input logic [7:0]  dp,
                                                  input int unsigned idx);
    return {dp[idx], dq[idx*LANE_DW +: LANE_DW]};
  endfunction

endpackage

// File: rtl/ssr_ctrl.sv
module ssr_ctrl #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ads_n,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              use_en,
  output logic [ADDR_W-1:0] use_addr,
  output logic              sel_q,
  output logic [ADDR_W-1:0] addr_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      addr_q <= '0;
    end else if (!ads_n) begin
      sel_q <= !ce_n;
      if (!ce_n) addr_q <= addr;
    end
  end

  always_comb begin
    use_en   = ads_n ? sel_q  : !ce_n;
    use_addr = ads_n ? addr_q : addr;
  end

endmodule

// File: rtl/ssr_lane.sv
module ssr_lane #(
  parameter int unsigned AW = 10,
  parameter int unsigned W  = 9
) (
  input  logic          clk,
  input  logic          wr,
  input  logic [AW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/ssr_rdpath.sv
module ssr_rdpath #(
  parameter int unsigned WORD_W = 72
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              oe_n,
  output logic [WORD_W-1:0] word_q,
  output logic              drive
);

  logic rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= 1'b0;
    else     rd_q <= load;
  end

  always_ff @(posedge clk) begin
    if (rst)       word_q <= '0;
    else if (load) word_q <= rd_word;
  end

  assign drive = rd_q & ~oe_n;

endmodule

// File: rtl/ssr_sram.sv
module ssr_sram #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned STORE_AW = 10,
  parameter int unsigned LANES    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ads_n,
  input  logic                ce_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [LANES-1:0]    we_n,
  input  logic                oe_n,
  input  logic [LANES*8-1:0]  dq_in,
  input  logic [LANES-1:0]    dp_in,
  output logic [LANES*8-1:0]  dq_out,
  output logic [LANES-1:0]    dp_out,
  output logic                drive
);

  localparam int unsigned DQ_W   = LANES * 8;
  localparam int unsigned LANE_W = 9;
  localparam int unsigned WORD_W = LANES * LANE_W;

  // Named events for the checker.
  logic                acc_en;
  logic [ADDR_W-1:0]   acc_addr;
  logic [STORE_AW-1:0] acc_idx;
  logic                acc_wr;
  logic                acc_rd;
  logic                sel_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [WORD_W-1:0]   rd_word;
  logic [WORD_W-1:0]   word_q;

  ssr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ads_n    (ads_n),
    .ce_n     (ce_n),
    .addr     (addr),
    .use_en   (acc_en),
    .use_addr (acc_addr),
    .sel_q    (sel_q),
    .addr_q   (addr_q)
  );

  assign acc_idx = acc_addr[STORE_AW-1:0];
  assign acc_wr  = acc_en & (we_n != '1);
  assign acc_rd  = acc_en & (we_n == '1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;
    ssr_lane #(.AW(STORE_AW), .W(LANE_W)) u_lane (
      .clk   (clk),
      .wr    (acc_wr & ~we_n[g]),
      .idx   (acc_idx),
      .wdata ({dp_in[g], dq_in[g*8 +: 8]}),
      .rdata (lane_q)
    );
    assign rd_word[g*8 +: 8]  = lane_q[7:0];
    assign rd_word[DQ_W + g]  = lane_q[8];
  end

  ssr_rdpath #(.WORD_W(WORD_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .load    (acc_rd),
    .rd_word (rd_word),
    .oe_n    (oe_n),
    .word_q  (word_q),
    .drive   (drive)
  );

  assign dq_out = word_q[DQ_W-1:0];
  assign dp_out = word_q[WORD_W-1:DQ_W];

endmodule

// File: rtl/ssr_sram_chk.sv
module ssr_sram_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LANES  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               ads_n,
  input logic               ce_n,
  input logic [ADDR_W-1:0]  addr,
  input logic [LANES-1:0]   we_n,
  input logic               oe_n,
  input logic               drive,
  input logic               sel_q,
  input logic [ADDR_W-1:0]  addr_q,
  input logic               acc_rd,
  input logic [LANES*8-1:0] dq_out,
  input logic [LANES-1:0]   dp_out
);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!sel_q && addr_q == '0 && !drive));

  assert_desel_R2: assert property (@(posedge clk) disable iff (rst)
    (!ads_n && ce_n) |=> (!sel_q && !drive));

  assert_stay_R3: assert property (@(posedge clk) disable iff (rst)
    (ads_n && !sel_q) |=> (!sel_q && !drive));

  assert_latch_R4: assert property (@(posedge clk) disable iff (rst)
    (!ads_n && !ce_n) |=> (sel_q && addr_q == $past(addr)));

  assert_keep_R5: assert property (@(posedge clk) disable iff (rst)
    ads_n |=> ($stable(addr_q) && $stable(sel_q)));

  assert_oe_R8: assert property (@(posedge clk) disable iff (rst)
    drive |-> !oe_n);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> ($stable(dq_out) && $stable(dp_out)));

  assert_wrz_R11: assert property (@(posedge clk) disable iff (rst)
    (we_n != '1) |=> !drive);

endmodule

bind ssr_sram ssr_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ads_n  (ads_n),
  .ce_n   (ce_n),
  .addr   (addr),
  .we_n   (we_n),
  .oe_n   (oe_n),
  .drive  (drive),
  .sel_q  (sel_q),
  .addr_q (addr_q),
  .acc_rd (acc_rd),
  .dq_out (dq_out),
  .dp_out (dp_out)
);

// File: tb/tb_ssr_sram.sv
module tb_ssr_sram;

  typedef struct packed {
    logic        ads_n;
    logic        ce_n;
    logic        oe_n;
    logic [7:0]  we_n;
    logic [15:0] addr;
    logic [71:0] din;
    logic        exp_drv;
    logic        chk_dat;
    logic [71:0] exp_dat;
  } vec_t;

  localparam logic [71:0] D0 = 72'hA4_0123456789ABCDEF;
  localparam logic [71:0] D1 = 72'h3C_FEDCBA9876543210;
  localparam logic [71:0] PL = 72'hFF_FFFFFFFFFFFFFF77;
  localparam logic [71:0] MG = 72'hA5_0123456789ABCD77;
  localparam int NV = 12;

  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,8'h00,16'h0010,D0,     1'b0,1'b0,72'h0}, // R4 R6 R11 write
    '{1'b0,1'b0,1'b0,8'h00,16'h0011,D1,     1'b0,1'b0,72'h0}, // R4 write
    '{1'b0,1'b0,1'b0,8'hFF,16'h0010,72'h0,  1'b1,1'b1,D0},    // R4 R9 read
    '{1'b1,1'b1,1'b0,8'hFF,16'h0011,72'h0,  1'b1,1'b1,D0},    // R5 held addr
    '{1'b1,1'b0,1'b0,8'hFE,16'h0000,PL,     1'b0,1'b1,D0},    // R7 R9 R11
    '{1'b1,1'b1,1'b0,8'hFF,16'h0000,72'h0,  1'b1,1'b1,MG},    // R7 merge
    '{1'b0,1'b1,1'b0,8'hFF,16'h0010,72'h0,  1'b0,1'b1,MG},    // R2 deselect
    '{1'b1,1'b0,1'b0,8'h00,16'h0011,72'h0,  1'b0,1'b1,MG},    // R3 write ignored
    '{1'b1,1'b0,1'b0,8'hFF,16'h0011,72'h0,  1'b0,1'b1,MG},    // R3 still off
    '{1'b0,1'b0,1'b0,8'hFF,16'h0011,72'h0,  1'b1,1'b1,D1},    // R3 R4 reselect
    '{1'b0,1'b0,1'b0,8'hFF,16'h0410,72'h0,  1'b1,1'b1,MG},    // R10 alias
    '{1'b1,1'b0,1'b1,8'hFF,16'h0000,72'h0,  1'b0,1'b1,MG}     // R8 oe high
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ads_n = 1'b1;
  logic        ce_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  we_n = 8'hFF;
  logic        oe_n = 1'b0;
  logic [63:0] dq_in = '0;
  logic [7:0]  dp_in = '0;
  logic [63:0] dq_out;
  logic [7:0]  dp_out;
  logic        drive;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ssr_sram dut (
    .clk(clk), .rst(rst), .ads_n(ads_n), .ce_n(ce_n), .addr(addr),
    .we_n(we_n), .oe_n(oe_n), .dq_in(dq_in), .dp_in(dp_in),
    .dq_out(dq_out), .dp_out(dp_out), .drive(drive)
  );

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic c, input logic o, input logic [7:0] w,
                      input logic [15:0] ad, input logic [71:0] d);
    @(negedge clk);
    ads_n = a; ce_n = c; oe_n = o; we_n = w; addr = ad;
    dq_in = d[63:0]; dp_in = d[71:64];
    @(posedge clk);
    #2;
  endtask

  // Expected word after lanes 0..upto were taken from nw, others from ow.
  function automatic logic [71:0] lane_mix(input logic [71:0] ow, input logic [71:0] nw,
                                           input int upto);
    logic [71:0] r;
    for (int b = 0; b < 72; b++) begin
      int ln;
      ln = (b < 64) ? b / 8 : b - 64;
      r[b] = (ln <= upto) ? nw[b] : ow[b];
    end
    return r;
  endfunction

  initial begin
    repeat (2) @(posedge clk);
    #2;
    chk("R1 reset drive", {71'h0, drive}, 72'h0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].ads_n, VEC[i].ce_n, VEC[i].oe_n, VEC[i].we_n, VEC[i].addr, VEC[i].din);
      chk($sformatf("vec%0d drive", i), {71'h0, drive}, {71'h0, VEC[i].exp_drv});
      if (VEC[i].chk_dat)
        chk($sformatf("vec%0d data", i), {dp_out, dq_out}, VEC[i].exp_dat);
    end

    // R8: output enable acts without a clock edge.
    step(1'b0, 1'b0, 1'b0, 8'hFF, 16'h0011, 72'h0);
    chk("R8 drive on", {71'h0, drive}, 72'h1);
    #1 oe_n = 1'b1; #0.5;
    chk("R8 async off", {71'h0, drive}, 72'h0);
    oe_n = 1'b0; #0.5;
    chk("R8 async on", {71'h0, drive}, 72'h1);

    // R7 R6: one lane at a time.
    step(1'b0, 1'b0, 1'b0, 8'h00, 16'h0020, D1);
    for (int ln = 0; ln < 8; ln++) begin
      step(1'b0, 1'b0, 1'b0, ~(8'h01 << ln), 16'h0020, ~D1);
      chk($sformatf("R6 lane%0d write drive", ln), {71'h0, drive}, 72'h0);
      step(1'b1, 1'b1, 1'b0, 8'hFF, 16'h0000, 72'h0);
      chk($sformatf("R7 lane%0d", ln), {dp_out, dq_out}, lane_mix(D1, ~D1, ln));
    end

    // R1: reset while selected, then a held-address read stays off.
    step(1'b0, 1'b0, 1'b0, 8'hFF, 16'h0020, 72'h0);
    chk("R1 pre-reset drive", {71'h0, drive}, 72'h1);
    @(negedge clk); rst = 1'b1;
    step(1'b1, 1'b0, 1'b0, 8'hFF, 16'h0000, 72'h0);
    @(negedge clk); rst = 1'b0;
    step(1'b1, 1'b0, 1'b0, 8'hFF, 16'h0000, 72'h0);
    chk("R1 after reset drive", {71'h0, drive}, 72'h0);
    step(1'b0, 1'b0, 1'b0, 8'hFF, 16'h0010, 72'h0);
    chk("R1 R4 reselect data", {dp_out, dq_out}, MG);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule